// File: doc/BRIEF.md
# Pipelined Dual-Precision Multiply-Accumulate Unit

This block is the arithmetic core of a filter engine. On every clock it accepts one data operand and one coefficient operand, both signed fixed-point fractions. It forms their product in one pipeline stage and folds that product into a running sum in the next stage. This gives a sustained rate of one multiply-accumulate per clock. A third register stage turns the wide running sum into a saturated output word.

The unit has two precisions. In long mode, 24-bit operands feed a 56-bit accumulator. In short mode, the low 16 bits of each operand feed an accumulator that wraps at 40 bits. A filter pass is framed by two markers. A `first` marker on the opening pair starts a fresh sum. A `last` marker on the closing pair requests a saturated result. Operand storage and address sequencing belong to the surrounding engine.

Top module: `fxp_mac_unit`

## Requirements
- R1: While `rst_n` is low and directly after its release, `res_valid` is 0 and `res_data` is 0.
- R2: With `mode_short` = 0, each operand is a 24-bit two's-complement fraction. The product is doubled (the duplicate sign bit is removed) and added into a 56-bit accumulator with binary point after bit 47.
- R3: Valid operand pairs on consecutive clocks are all accumulated, with no stall or bubble.
- R4: A valid pair with `in_first` = 1 replaces the accumulator contents with its own product, and the previous sum is discarded.
- R5: In a cycle with `in_valid` = 0, the operands and markers have no effect, and the running sum continues unchanged with the next valid pair.
- R6: A valid pair with `in_last` = 1 presented in cycle t makes `res_valid` high for one cycle in cycle t+3. The result includes that pair.
- R7: In long mode the output is accumulator bits [47:24], truncated, when bits [55:47] are all equal. Otherwise the output is 24'h7FFFFF for a positive sum or 24'h800000 for a negative sum.
- R8: With `mode_short` = 1, only bits [15:0] of each operand are used, and bits [23:16] are ignored. The doubled product is summed modulo 2^40. The mode is sampled with each pair, and a pass uses a single mode.
- R9: In short mode the output is accumulator bits [31:16] when bits [39:31] are all equal. Otherwise it is 16'h7FFF or 16'h8000 by sign. The 16-bit value is sign-extended onto the 24-bit `res_data`.
- R10: Intermediate sums are neither clipped nor saturated. A sum that leaves the output range and comes back gives the exact in-range result.
- R11: `res_data` keeps its last result while `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair valid |
| in_first | input | 1 | Pair opens a new sum |
| in_last | input | 1 | Pair closes the sum and requests a result |
| mode_short | input | 1 | 1 selects 16-bit mode, 0 selects 24-bit mode |
| op_data | input | 24 | Data operand |
| op_coef | input | 24 | Coefficient operand |
| res_valid | output | 1 | Result valid, one cycle per pass |
| res_data | output | 24 | Saturated result |

## Verification
The bench drives the extremes of the fraction range: full-scale negative times itself must clamp to the positive limit rather than wrap to the negative limit. It also runs a long pass whose sum climbs well past full scale and then returns. A design that clipped intermediate sums would report a wrong in-range value there. Short-mode passes are repeated with junk in the upper operand bits. They expose a design that multiplies full words or forgets to sign-extend the 16-bit result. Gapped and back-to-back passes catch a sum that is corrupted by idle cycles, one that leaks across a `first` marker, or a result strobe placed off by a cycle.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;

  // Control that travels alongside each operand pair down the pipeline
  typedef struct packed {
    logic vld;
    logic first;
    logic last;
    logic short_m;
  } mac_tag_t;

endpackage

// File: rtl/fxp_mac_mul.sv
module fxp_mac_mul
  import fxp_mac_pkg::*;
#(
  parameter int DWL = 24,
  parameter int DWS = 16,
  parameter int AWL = 56
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_first,
  input  logic                  in_last,
  input  logic                  mode_short,
  input  logic [DWL-1:0]        op_a,
  input  logic [DWL-1:0]        op_b,
  output mac_tag_t              tag_q,
  output logic signed [AWL-1:0] prod_q
);

  localparam int PW  = 2 * DWL;
  localparam int EXT = AWL - PW;
  localparam int SPW = 2 * DWS;

  logic signed [DWL-1:0] a_sel;
  logic signed [DWL-1:0] b_sel;
  logic signed [PW-1:0]  prod_full;
  logic signed [AWL-1:0] prod_d;
  mac_tag_t              tag_d;

  // Operand selection: short mode sign-extends the low half-word
  always_comb begin
    if (mode_short) begin
      a_sel = {{(DWL-DWS){op_a[DWS-1]}}, op_a[DWS-1:0]};
      b_sel = {{(DWL-DWS){op_b[DWS-1]}}, op_b[DWS-1:0]};
    end else begin
      a_sel = op_a;
      b_sel = op_b;
    end
    prod_full = a_sel * b_sel;
    prod_d    = {{EXT{prod_full[PW-1]}}, prod_full} <<< 1;
    tag_d.vld     = in_valid;
    tag_d.first   = in_first;
    tag_d.last    = in_last;
    tag_d.short_m = mode_short;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      prod_q <= '0;
    end else begin
      tag_q <= tag_d;
      if (in_valid) begin
        prod_q <= prod_d;
      end
    end
  end

  // R8: a short-mode product never reaches above its 33-bit signed range
  a_r8_short_range: assert property (@(posedge clk) disable iff (!rst_n)
    tag_q.vld && tag_q.short_m |->
      (prod_q[AWL-1:SPW] == '0) || (prod_q[AWL-1:SPW] == '1));

endmodule

// File: rtl/fxp_mac_acc.sv
module fxp_mac_acc
  import fxp_mac_pkg::*;
#(
  parameter int AWL = 56,
  parameter int AWS = 40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  mac_tag_t              tag_i,
  input  logic signed [AWL-1:0] prod_i,
  output mac_tag_t              tag_q,
  output logic signed [AWL-1:0] acc_q
);

  localparam int SEXT = AWL - AWS;

  logic signed [AWL-1:0] acc_sum;
  logic signed [AWL-1:0] acc_base;
  logic signed [AWL-1:0] acc_d;

  always_comb begin
    acc_sum  = acc_q + prod_i;
    acc_base = tag_i.first ? prod_i : acc_sum;
    if (tag_i.short_m) begin
      acc_d = {{SEXT{acc_base[AWS-1]}}, acc_base[AWS-1:0]};
    end else begin
      acc_d = acc_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      tag_q <= '0;
    end else begin
      tag_q <= tag_i;
      if (tag_i.vld) begin
        acc_q <= acc_d;
      end
    end
  end

  // R4: a first pair in long mode leaves exactly its product in the sum
  a_r4_first_loads: assert property (@(posedge clk) disable iff (!rst_n)
    tag_i.vld && tag_i.first && !tag_i.short_m |=> acc_q == $past(prod_i));

  // R5: idle cycles leave the running sum untouched
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_i.vld |=> $stable(acc_q));

endmodule

// File: rtl/fxp_mac_sat.sv
module fxp_mac_sat
  import fxp_mac_pkg::*;
#(
  parameter int DWL = 24,
  parameter int DWS = 16,
  parameter int AWL = 56,
  parameter int AWS = 40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  mac_tag_t              tag_i,
  input  logic signed [AWL-1:0] acc_i,
  output logic                  res_valid,
  output logic [DWL-1:0]        res_data
);

  localparam int PW  = 2 * DWL;
  localparam int SPW = 2 * DWS;

  logic [AWL-PW:0]  guard_l;
  logic [AWS-SPW:0] guard_s;
  logic             ok_l;
  logic             ok_s;
  logic [DWL-1:0]   long_v;
  logic [DWS-1:0]   s16;
  logic [DWL-1:0]   res_d;
  logic             fire;

  always_comb begin
    guard_l = acc_i[AWL-1:PW-1];
    guard_s = acc_i[AWS-1:SPW-1];
    ok_l    = (guard_l == '0) || (guard_l == '1);
    ok_s    = (guard_s == '0) || (guard_s == '1);
    if (ok_l) begin
      long_v = acc_i[PW-1:DWL];
    end else if (acc_i[AWL-1]) begin
      long_v = {1'b1, {(DWL-1){1'b0}}};
    end else begin
      long_v = {1'b0, {(DWL-1){1'b1}}};
    end
    if (ok_s) begin
      s16 = acc_i[SPW-1:DWS];
    end else if (acc_i[AWS-1]) begin
      s16 = {1'b1, {(DWS-1){1'b0}}};
    end else begin
      s16 = {1'b0, {(DWS-1){1'b1}}};
    end
    res_d = tag_i.short_m ? {{(DWL-DWS){s16[DWS-1]}}, s16} : long_v;
    fire  = tag_i.vld & tag_i.last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= fire;
      if (fire) begin
        res_data <= res_d;
      end
    end
  end

  // R9: a short-mode result is a sign-extended 16-bit word
  a_r9_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fire && tag_i.short_m) |->
      (res_data[DWL-1:DWS-1] == '0) || (res_data[DWL-1:DWS-1] == '1));

  // R11: output word is steady between results
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_data));

endmodule

// File: rtl/fxp_mac_unit.sv
module fxp_mac_unit
  import fxp_mac_pkg::*;
#(
  parameter int DWL = 24,
  parameter int DWS = 16,
  parameter int AWL = 56,
  parameter int AWS = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_first,
  input  logic           in_last,
  input  logic           mode_short,
  input  logic [DWL-1:0] op_data,
  input  logic [DWL-1:0] op_coef,
  output logic           res_valid,
  output logic [DWL-1:0] res_data
);

  mac_tag_t              tag_m;
  mac_tag_t              tag_a;
  logic signed [AWL-1:0] prod_m;
  logic signed [AWL-1:0] acc_a;

  fxp_mac_mul #(.DWL(DWL), .DWS(DWS), .AWL(AWL)) u_mul (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_first   (in_first),
    .in_last    (in_last),
    .mode_short (mode_short),
    .op_a       (op_data),
    .op_b       (op_coef),
    .tag_q      (tag_m),
    .prod_q     (prod_m)
  );

  fxp_mac_acc #(.AWL(AWL), .AWS(AWS)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .tag_i  (tag_m),
    .prod_i (prod_m),
    .tag_q  (tag_a),
    .acc_q  (acc_a)
  );

  fxp_mac_sat #(.DWL(DWL), .DWS(DWS), .AWL(AWL), .AWS(AWS)) u_sat (
    .clk       (clk),
    .rst_n     (rst_n),
    .tag_i     (tag_a),
    .acc_i     (acc_a),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  // R6: a closing pair yields a result strobe three clocks later
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_last |-> ##3 res_valid);

endmodule

// File: tb/fxp_mac_unit_tb_top.sv
module fxp_mac_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_first, in_last, mode_short;
  logic [23:0] op_data, op_coef;
  logic        res_valid;
  logic [23:0] res_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // reference model state
  longint      m_acc  = 0;
  logic [23:0] m_hold = 24'h0;
  bit          qv[$];
  logic [23:0] qd[$];
  string       qt[$];

  always #4 clk = ~clk;

  fxp_mac_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .mode_short(mode_short), .op_data(op_data),
    .op_coef(op_coef), .res_valid(res_valid), .res_data(res_data)
  );

  function automatic longint sx(input longint x, input int w);
    return (x <<< (64 - w)) >>> (64 - w);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [23:0] act,
                     input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] model_out(input bit s);
    longint g;
    logic [15:0] o16;
    if (!s) begin
      g = m_acc >>> 47;
      if (g == 0 || g == -1) return 24'((m_acc >>> 24) & 64'hFFFFFF);
      return (m_acc < 0) ? 24'h800000 : 24'h7FFFFF;
    end
    g = m_acc >>> 31;
    if (g == 0 || g == -1) begin
      o16 = 16'((m_acc >>> 16) & 64'hFFFF);
      return {{8{o16[15]}}, o16};
    end
    return (m_acc < 0) ? 24'hFF8000 : 24'h007FFF;
  endfunction

  // one clock: check the output due now, drive the next pair, update model
  task automatic cyc(input bit v, input bit f, input bit l, input bit s,
                     input logic [23:0] a, input logic [23:0] b,
                     input string tag);
    bit          ev;
    logic [23:0] ed;
    string       et;
    longint      pa, pb, p;
    @(negedge clk);
    ev = qv.pop_front();
    ed = qd.pop_front();
    et = qt.pop_front();
    chk(res_valid == ev, {et, " valid strobe"}, {23'h0, res_valid}, {23'h0, ev});
    chk(res_data == ed, {et, " data"}, res_data, ed);
    in_valid = v; in_first = f; in_last = l; mode_short = s;
    op_data = a; op_coef = b;
    if (v) begin
      pa = s ? sx(longint'(a[15:0]), 16) : sx(longint'(a), 24);
      pb = s ? sx(longint'(b[15:0]), 16) : sx(longint'(b), 24);
      p  = pa * pb * 2;
      m_acc = f ? p : m_acc + p;
      m_acc = s ? sx(m_acc, 40) : sx(m_acc, 56);
    end
    if (v && l) begin
      m_hold = model_out(s);
      qv.push_back(1'b1);
    end else begin
      qv.push_back(1'b0);
    end
    qd.push_back(m_hold);
    qt.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 24'h0, 24'h0, tag);
  endtask

  // a pass of n identical pairs
  task automatic pass_same(input int n, input bit s, input logic [23:0] a,
                           input logic [23:0] b, input string tag);
    for (int i = 0; i < n; i++)
      cyc(1, i == 0, i == n - 1, s, a, b, tag);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 0; in_first = 0; in_last = 0; mode_short = 0;
    op_data = 0; op_coef = 0;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R1 reset valid", {23'h0, res_valid}, 24'h0);
    chk(res_data == 24'h0, "R1 reset data", res_data, 24'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      qv.push_back(1'b0); qd.push_back(24'h0); qt.push_back("R1");
    end
    idle(2, "R1");

    // R2: long-mode fraction products, 0.5*0.5 and mixed signs
    pass_same(1, 0, 24'h400000, 24'h400000, "R2");
    cyc(1, 1, 0, 0, 24'h123456, 24'h3A0F00, "R2");
    cyc(1, 0, 0, 0, 24'hF00001, 24'h654321, "R2");
    cyc(1, 0, 1, 0, 24'hC00000, 24'hE00000, "R2");
    idle(4, "R2");

    // R3/R6: back-to-back passes with no bubbles, one-pair passes included
    pass_same(3, 0, 24'h100000, 24'h200000, "R3");
    pass_same(1, 0, 24'h7FFFFF, 24'h000100, "R6");
    pass_same(2, 0, 24'hFFF000, 24'h080000, "R3");
    // R4: first marker discards a large prior sum
    pass_same(5, 0, 24'h7FFFFF, 24'h7FFFFF, "R4");
    pass_same(1, 0, 24'h000010, 24'h000020, "R4");
    idle(4, "R4");

    // R5: idle cycles with junk operands and markers inside a pass
    cyc(1, 1, 0, 0, 24'h200000, 24'h200000, "R5");
    cyc(0, 1, 1, 1, 24'h7FFFFF, 24'h7FFFFF, "R5");
    cyc(0, 1, 0, 0, 24'h800000, 24'h123456, "R5");
    cyc(1, 0, 1, 0, 24'h100000, 24'h300000, "R5");
    idle(4, "R5");

    // R7: positive and negative clamps, full-scale negative squared
    pass_same(4, 0, 24'h7FFFFF, 24'h7FFFFF, "R7");
    pass_same(3, 0, 24'h800000, 24'h7FFFFF, "R7");
    pass_same(1, 0, 24'h800000, 24'h800000, "R7");
    idle(4, "R7");

    // R10: sum leaves the range and returns
    cyc(1, 1, 0, 0, 24'h7FFFFF, 24'h7FFFFF, "R10");
    cyc(1, 0, 0, 0, 24'h7FFFFF, 24'h7FFFFF, "R10");
    cyc(1, 0, 0, 0, 24'h7FFFFF, 24'h7FFFFF, "R10");
    cyc(1, 0, 0, 0, 24'h800000, 24'h7FFFFF, "R10");
    cyc(1, 0, 0, 0, 24'h800000, 24'h7FFFFF, "R10");
    cyc(1, 0, 1, 0, 24'h800000, 24'h7FF000, "R10");
    idle(6, "R11");

    // R8/R9: short mode, clean then with junk upper bytes
    pass_same(2, 1, 24'h002000, 24'h004000, "R8");
    pass_same(2, 1, 24'hA52000, 24'h5A4000, "R8");
    pass_same(3, 1, 24'h00C000, 24'h003000, "R9");
    pass_same(4, 1, 24'hFF7FFF, 24'h337FFF, "R9");
    pass_same(3, 1, 24'h008000, 24'hC37FFF, "R9");
    pass_same(1, 1, 24'h778000, 24'h118000, "R9");
    idle(4, "R11");

    // R3: mixed passes with random gaps
    for (int k = 0; k < 40; k++) begin
      int n = $urandom_range(1, 8);
      bit s = 1'($urandom_range(0, 1));
      for (int i = 0; i < n; i++) begin
        cyc(1, i == 0, i == n - 1, s, 24'($urandom), 24'($urandom), "R3");
        if ($urandom_range(0, 3) == 0) idle(1, "R5");
      end
    end
    idle(5, "R11");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule